// File: doc/BRIEF.md
# Addressed Byte Bus Device Controller

This block sits on the peripheral side of a shared byte bus that many controllers watch at once. Every transfer has two phases. In the first, the processor broadcasts a control byte. The upper five bits of that byte select one device. The lower three bits give an order code that names the operation. A controller whose address matches attaches itself to the bus. It also latches the order code and the direction bit that came with the byte. Every other controller stays detached.

In the second phase, exactly one data byte moves through the selected register. On an output phase it goes into the function register or the data-out register. On an input phase it comes out of the status byte or the input buffer. After that one byte, the controller detaches again.

On the device side there are two paths. The output path has a data-out byte that is held valid until the peripheral acknowledges it, and a function byte that comes with a one-cycle load pulse. The input path has a one-byte input buffer that the peripheral fills with a valid/ready handshake.

Top module: `byte_bus_dev_ctrl`

## Requirements
- R1: After reset the controller is detached. `bus_oe` is 0 and `bus_data_out` is 0x00. `dev_data_out`, `dev_func_out` and `dev_out_valid` are 0, and `dev_in_ready` is 1.
- R2: When `control_strobe` is sampled high, the controller attaches in the next cycle if `bus_data_in[7:3]` equals `DEV_ADDR`. Otherwise it detaches, which also drops an earlier selection.
- R3: `bus_oe` is 1 only while the controller is attached and the direction bit latched with the control byte was 1 (input). In every other cycle `bus_oe` is 0 and `bus_data_out` is 0x00.
- R4: If `data_strobe` is sampled high while the controller is attached (and `control_strobe` is low), exactly one byte is transferred, and the controller is detached from the next cycle on.
- R5: If `data_strobe` arrives while the controller is detached, it changes no register and produces no device-side pulse.
- R6: Output order 0 (function) stores the data byte in `dev_func_out` and raises `dev_func_load` for exactly one cycle.
- R7: Output order 1 (data) stores the byte in `dev_data_out` and sets `dev_out_valid`. `dev_out_valid` stays high until a cycle in which `dev_out_ack` is high.
- R8: Input order 0 (status) returns the byte {input buffer full, output pending, `dev_status_in` registered one cycle}, with the full flag in bit 7 and the pending flag in bit 6.
- R9: The input buffer captures `dev_in_data` when `dev_in_valid` is high and the buffer is empty. `dev_in_ready` shows that the buffer is empty. Input order 1 (data) returns the buffered byte and empties the buffer.
- R10: Input order 2 returns the data-out register and input order 3 returns the function register. Neither read changes any state.
- R11: An undefined order still attaches and detaches the controller normally. Input orders 4 to 7 drive 0x00, and output orders 2 to 7 discard the byte.
- R12: The transfer direction is the value of `bus_dir` at the control strobe, with 1 meaning input. The value of `bus_dir` during the data phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data_in | input | 8 | Byte driven by the processor (control or output data) |
| control_strobe | input | 1 | Marks a control byte on `bus_data_in` |
| data_strobe | input | 1 | Marks the data phase |
| bus_dir | input | 1 | Direction, sampled with the control byte: 1 = input to processor |
| bus_data_out | output | 8 | Byte this controller drives during an input phase |
| bus_oe | output | 1 | Enable for this controller's bus driver |
| bus_attached | output | 1 | Controller is selected for the pending data phase |
| dev_func_out | output | 8 | Function register |
| dev_func_load | output | 1 | One-cycle pulse after a function write |
| dev_data_out | output | 8 | Data-out register |
| dev_out_valid | output | 1 | Data-out byte not yet taken by the peripheral |
| dev_out_ack | input | 1 | Peripheral has taken the data-out byte |
| dev_status_in | input | 6 | Peripheral status flags |
| dev_in_data | input | 8 | Byte offered by the peripheral |
| dev_in_valid | input | 1 | Peripheral offers `dev_in_data` |
| dev_in_ready | output | 1 | Input buffer is empty |

## Verification
Some properties are checked on every cycle by assertions:
- attach and detach after a control byte, for both a matching and a foreign address;
- the single-byte detach;
- the driver enable never being high while detached;
- an undefined input order driving zero;
- a stray data strobe leaving the output registers still;
- the function pulse lasting one cycle;
- `dev_out_valid` holding until acknowledged.

Other behaviour can only be shown by the bench scenarios, because it depends on the sequence of transfers. That includes the returned status, input and readback bytes, the input buffer's full/empty handshake, and the discarding of undefined output bytes. It also includes the rule that the direction is taken from the control phase.

// File: rtl/bbd_pkg.sv
// Package: shared order codes and widths for the byte bus device controller.
// Assumes an 8-bit bus whose control byte packs the address above a 3-bit order.
package bbd_pkg;
    localparam int ORDER_W = 3;

    // Output orders (direction bit 0 at control phase)
    localparam logic [ORDER_W-1:0] ORD_OUT_FUNC = 3'd0;
    localparam logic [ORDER_W-1:0] ORD_OUT_DATA = 3'd1;

    // Input orders (direction bit 1 at control phase)
    localparam logic [ORDER_W-1:0] ORD_IN_STAT    = 3'd0;
    localparam logic [ORDER_W-1:0] ORD_IN_DATA    = 3'd1;
    localparam logic [ORDER_W-1:0] ORD_IN_RB_DATA = 3'd2;
    localparam logic [ORDER_W-1:0] ORD_IN_RB_FUNC = 3'd3;
endpackage

// File: rtl/bbd_select.sv
// Module: bbd_select
// Decodes the broadcast control byte, holds the attach state, the latched order
// and the latched direction, and produces one-cycle fire signals for the data
// phase. Assumes the strobes are synchronous one-cycle pulses. A control strobe
// takes precedence over a data strobe in the same cycle.
module bbd_select #(
    parameter int DATA_W  = 8,
    parameter int ORDER_W = 3,
    parameter int ADDR_W  = DATA_W - ORDER_W,
    parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  ctrl_byte,
    input  logic               control_strobe,
    input  logic               data_strobe,
    input  logic               dir_in,
    output logic               attached,
    output logic               dir_q,
    output logic [ORDER_W-1:0] order_q,
    output logic               wr_fire,
    output logic               rd_fire
);
    logic attached_q;
    logic fire;

    // Attach on a matching control byte, detach on a foreign one or after the data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attached_q <= 1'b0;
            dir_q      <= 1'b0;
            order_q    <= '0;
        end else if (control_strobe) begin
            attached_q <= (ctrl_byte[DATA_W-1:ORDER_W] == DEV_ADDR);
            dir_q      <= dir_in;
            order_q    <= ctrl_byte[ORDER_W-1:0];
        end else if (data_strobe && attached_q) begin
            attached_q <= 1'b0;
        end
    end

    // Data phase qualifies only while attached and not overridden by a control byte
    always_comb begin
        fire    = data_strobe && !control_strobe && attached_q;
        wr_fire = fire && !dir_q;
        rd_fire = fire && dir_q;
    end

    assign attached = attached_q;
endmodule

// File: rtl/bbd_out_path.sv
// Module: bbd_out_path
// Holds the function and data-out registers written by output orders and runs
// the valid/acknowledge handshake on the data-out byte. Undefined output orders
// fall through and change nothing. A new data write overrides a same-cycle ack.
module bbd_out_path #(
    parameter int DATA_W  = 8,
    parameter int ORDER_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_fire,
    input  logic [ORDER_W-1:0] order,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               out_ack,
    output logic [DATA_W-1:0]  func_q,
    output logic               func_load_q,
    output logic [DATA_W-1:0]  data_q,
    output logic               pend_q
);
    import bbd_pkg::*;

    logic wr_func;
    logic wr_data;

    // Order decode for the two defined output operations
    always_comb begin
        wr_func = wr_fire && (order == ORD_OUT_FUNC);
        wr_data = wr_fire && (order == ORD_OUT_DATA);
    end

    // Function register plus one-cycle load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q      <= '0;
            func_load_q <= 1'b0;
        end else begin
            func_load_q <= wr_func;
            if (wr_func) func_q <= wdata;
        end
    end

    // Data-out register and its pending flag (held until acknowledged)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_q <= 1'b0;
        end else if (wr_data) begin
            data_q <= wdata;
            pend_q <= 1'b1;
        end else if (out_ack) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bbd_in_path.sv
// Module: bbd_in_path
// One-byte input buffer filled by the peripheral with a valid/ready handshake
// and emptied by the data-input order. It also registers the peripheral status
// flags and assembles the status byte. When the buffer is empty, a same-cycle
// capture wins over a read.
module bbd_in_path #(
    parameter int DATA_W = 8,
    parameter int FLAG_W = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              out_pend,
    output logic [DATA_W-1:0] in_q,
    output logic              full_q,
    output logic [DATA_W-1:0] status_byte
);
    logic [FLAG_W-1:0] flags_q;
    logic              capture;

    // Capture only into an empty buffer
    always_comb capture = in_valid && !full_q;

    // Input buffer and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            full_q <= 1'b0;
        end else begin
            if (take)    full_q <= 1'b0;
            if (capture) begin
                full_q <= 1'b1;
                in_q   <= in_data;
            end
        end
    end

    // Register the peripheral status flags
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_in;
    end

    // Status byte: full in the top bit, pending next, flags below
    always_comb status_byte = {full_q, out_pend, flags_q};
endmodule

// File: rtl/byte_bus_dev_ctrl.sv
// Module: byte_bus_dev_ctrl (top)
// A peripheral controller on a shared byte bus. A control byte selects the
// device and an order for one transfer, and the controller then moves a single
// data byte and detaches. It drives the bus only during an input data phase.
// Assumes synchronous, one-cycle strobes from the bus master.
module byte_bus_dev_ctrl #(
    parameter int DATA_W      = 8,
    parameter int ORDER_W     = 3,
    parameter int ADDR_W      = DATA_W - ORDER_W,
    parameter int FLAG_W      = DATA_W - 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 5'h0A,
    parameter bit READBACK_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              control_strobe,
    input  logic              data_strobe,
    input  logic              bus_dir,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_oe,
    output logic              bus_attached,
    output logic [DATA_W-1:0] dev_func_out,
    output logic              dev_func_load,
    output logic [DATA_W-1:0] dev_data_out,
    output logic              dev_out_valid,
    input  logic              dev_out_ack,
    input  logic [FLAG_W-1:0] dev_status_in,
    input  logic [DATA_W-1:0] dev_in_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready
);
    import bbd_pkg::*;

    logic               dir_q;
    logic [ORDER_W-1:0] ord_q;
    logic               wr_fire;
    logic               rd_fire;
    logic [DATA_W-1:0]  func_q;
    logic [DATA_W-1:0]  data_q;
    logic               pend_q;
    logic [DATA_W-1:0]  in_q;
    logic               full_q;
    logic [DATA_W-1:0]  status_byte;
    logic [DATA_W-1:0]  rb_data;
    logic [DATA_W-1:0]  rb_func;
    logic [DATA_W-1:0]  rd_byte;
    logic               take;

    bbd_select #(.DATA_W(DATA_W), .ORDER_W(ORDER_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) sel_i (
        .clk(clk), .rst_n(rst_n), .ctrl_byte(bus_data_in),
        .control_strobe(control_strobe), .data_strobe(data_strobe), .dir_in(bus_dir),
        .attached(bus_attached), .dir_q(dir_q), .order_q(ord_q),
        .wr_fire(wr_fire), .rd_fire(rd_fire)
    );

    bbd_out_path #(.DATA_W(DATA_W), .ORDER_W(ORDER_W)) out_i (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .order(ord_q), .wdata(bus_data_in),
        .out_ack(dev_out_ack), .func_q(func_q), .func_load_q(dev_func_load),
        .data_q(data_q), .pend_q(pend_q)
    );

    // Data-input order empties the buffer
    always_comb take = rd_fire && (ord_q == ORD_IN_DATA);

    bbd_in_path #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) in_i (
        .clk(clk), .rst_n(rst_n), .take(take), .in_data(dev_in_data),
        .in_valid(dev_in_valid), .flags_in(dev_status_in), .out_pend(pend_q),
        .in_q(in_q), .full_q(full_q), .status_byte(status_byte)
    );

    // Optional readback of the output registers
    generate
        if (READBACK_EN) begin : g_rb
            assign rb_data = data_q;
            assign rb_func = func_q;
        end else begin : g_no_rb
            assign rb_data = '0;
            assign rb_func = '0;
        end
    endgenerate

    // Input-phase byte selection; undefined orders read zero
    always_comb begin
        case (ord_q)
            ORD_IN_STAT:    rd_byte = status_byte;
            ORD_IN_DATA:    rd_byte = in_q;
            ORD_IN_RB_DATA: rd_byte = rb_data;
            ORD_IN_RB_FUNC: rd_byte = rb_func;
            default:        rd_byte = '0;
        endcase
    end

    // Bus drive only while attached for an input phase
    always_comb begin
        bus_oe       = bus_attached && dir_q;
        bus_data_out = bus_oe ? rd_byte : '0;
    end

    assign dev_func_out  = func_q;
    assign dev_data_out  = data_q;
    assign dev_out_valid = pend_q;
    assign dev_in_ready  = !full_q;
endmodule

// File: rtl/bbd_checker.sv
// Module: bbd_checker
// Cycle-level properties of the byte bus device controller, bound to the top.
module bbd_checker #(
    parameter int DATA_W  = 8,
    parameter int ORDER_W = 3,
    parameter int ADDR_W  = DATA_W - ORDER_W,
    parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               control_strobe,
    input logic               data_strobe,
    input logic [DATA_W-1:0]  bus_data_in,
    input logic               bus_attached,
    input logic               bus_oe,
    input logic [DATA_W-1:0]  bus_data_out,
    input logic               dev_func_load,
    input logic [DATA_W-1:0]  dev_func_out,
    input logic [DATA_W-1:0]  dev_data_out,
    input logic               dev_out_valid,
    input logic               dev_out_ack,
    input logic [ORDER_W-1:0] order_q
);
    a_r2_own_addr_attaches: assert property (@(posedge clk) disable iff (!rst_n)
        (control_strobe && bus_data_in[DATA_W-1:ORDER_W] == DEV_ADDR) |=> bus_attached);

    a_r2_foreign_addr_detaches: assert property (@(posedge clk) disable iff (!rst_n)
        (control_strobe && bus_data_in[DATA_W-1:ORDER_W] != DEV_ADDR) |=> !bus_attached);

    a_r3_drive_needs_attach: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_attached);

    a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data_out == '0));

    a_r4_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !control_strobe && bus_attached) |=> (!bus_attached && !bus_oe));

    a_r5_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !control_strobe && !bus_attached) |=>
        ($stable(dev_data_out) && $stable(dev_func_out) && !dev_func_load));

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        dev_func_load |=> !dev_func_load);

    a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ack) |=> dev_out_valid);

    a_r11_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && order_q[ORDER_W-1]) |-> (bus_data_out == '0));
endmodule

bind byte_bus_dev_ctrl bbd_checker #(
    .DATA_W(DATA_W), .ORDER_W(ORDER_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .control_strobe(control_strobe), .data_strobe(data_strobe),
    .bus_data_in(bus_data_in), .bus_attached(bus_attached), .bus_oe(bus_oe),
    .bus_data_out(bus_data_out), .dev_func_load(dev_func_load), .dev_func_out(dev_func_out),
    .dev_data_out(dev_data_out), .dev_out_valid(dev_out_valid), .dev_out_ack(dev_out_ack),
    .order_q(ord_q)
);

// File: tb/byte_bus_dev_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random transfers against a bench model.
module byte_bus_dev_ctrl_tb_top;
    localparam logic [4:0] MY_ADDR = 5'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_data_in = '0;
    logic       control_strobe = 1'b0;
    logic       data_strobe = 1'b0;
    logic       bus_dir = 1'b0;
    logic [7:0] bus_data_out;
    logic       bus_oe;
    logic       bus_attached;
    logic [7:0] dev_func_out;
    logic       dev_func_load;
    logic [7:0] dev_data_out;
    logic       dev_out_valid;
    logic       dev_out_ack = 1'b0;
    logic [5:0] dev_status_in = '0;
    logic [7:0] dev_in_data = '0;
    logic       dev_in_valid = 1'b0;
    logic       dev_in_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model of the controller's visible state
    logic [7:0] m_func = '0, m_data = '0, m_in = '0;
    logic       m_pend = 1'b0, m_full = 1'b0;
    logic [5:0] m_flags = '0;

    always #4 clk = ~clk;

    byte_bus_dev_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_data_in(bus_data_in), .control_strobe(control_strobe),
        .data_strobe(data_strobe), .bus_dir(bus_dir), .bus_data_out(bus_data_out),
        .bus_oe(bus_oe), .bus_attached(bus_attached), .dev_func_out(dev_func_out),
        .dev_func_load(dev_func_load), .dev_data_out(dev_data_out), .dev_out_valid(dev_out_valid),
        .dev_out_ack(dev_out_ack), .dev_status_in(dev_status_in), .dev_in_data(dev_in_data),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Expected byte for an input order (R8, R9, R10, R11)
    function automatic logic [7:0] exp_rd(input logic [2:0] ord);
        case (ord)
            3'd0: return {m_full, m_pend, m_flags};
            3'd1: return m_in;
            3'd2: return m_data;
            3'd3: return m_func;
            default: return 8'h00;
        endcase
    endfunction

    // Checks every visible register against the model
    task automatic chk_regs(input string req);
        chk({req, " func"}, dev_func_out, m_func);
        chk({req, " data"}, dev_data_out, m_data);
        chk({req, " valid"}, {7'd0, dev_out_valid}, {7'd0, m_pend});
        chk({req, " ready"}, {7'd0, dev_in_ready}, {7'd0, !m_full});
    endtask

    // Full two-phase transfer; data_dir is bus_dir during data phase (R12)
    task automatic xfer(input logic [4:0] addr, input logic dir, input logic [2:0] ord,
                        input logic [7:0] wdata, input logic data_dir);
        bit hit;
        hit = (addr == MY_ADDR);
        @(negedge clk);
        bus_data_in = {addr, ord}; bus_dir = dir; control_strobe = 1'b1;
        @(negedge clk);
        control_strobe = 1'b0;
        chk("R2 attach", {7'd0, bus_attached}, {7'd0, hit});
        chk("R3 oe", {7'd0, bus_oe}, {7'd0, hit && dir});
        if (hit && dir) chk("R8/R9/R10/R11 read byte", bus_data_out, exp_rd(ord));
        else            chk("R3 idle byte", bus_data_out, 8'h00);
        bus_data_in = wdata; bus_dir = data_dir; data_strobe = 1'b1;
        @(negedge clk);
        data_strobe = 1'b0; bus_dir = 1'b0;
        if (hit) begin
            if (dir && ord == 3'd1) m_full = 1'b0;
            if (!dir && ord == 3'd0) m_func = wdata;
            if (!dir && ord == 3'd1) begin m_data = wdata; m_pend = 1'b1; end
        end
        chk("R4 detached", {7'd0, bus_attached}, 8'h00);
        chk("R4 oe low", {7'd0, bus_oe}, 8'h00);
        chk("R6 load pulse", {7'd0, dev_func_load}, {7'd0, hit && !dir && ord == 3'd0});
        chk_regs(hit ? "R7/R11 regs" : "R5 regs");
        @(negedge clk);
        chk("R6 pulse ends", {7'd0, dev_func_load}, 8'h00);
    endtask

    task automatic stray(input logic [7:0] wdata, input logic dir);
        @(negedge clk);
        bus_data_in = wdata; bus_dir = dir; data_strobe = 1'b1;
        @(negedge clk);
        data_strobe = 1'b0;
        chk("R5 no attach", {7'd0, bus_attached}, 8'h00);
        chk("R5 no pulse", {7'd0, dev_func_load}, 8'h00);
        chk_regs("R5 regs");
    endtask

    task automatic push_in(input logic [7:0] b);
        @(negedge clk);
        dev_in_valid = 1'b1; dev_in_data = b;
        @(negedge clk);
        dev_in_valid = 1'b0;
        if (!m_full) begin m_in = b; m_full = 1'b1; end
        chk("R9 ready", {7'd0, dev_in_ready}, {7'd0, !m_full});
    endtask

    task automatic ack_out();
        @(negedge clk);
        dev_out_ack = 1'b1;
        @(negedge clk);
        dev_out_ack = 1'b0;
        m_pend = 1'b0;
        chk("R7 valid cleared", {7'd0, dev_out_valid}, 8'h00);
    endtask

    task automatic set_flags(input logic [5:0] f);
        @(negedge clk);
        dev_status_in = f;
        @(negedge clk);
        m_flags = f;
    endtask

    // Watchdog: counts as a failed check
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 attached", {7'd0, bus_attached}, 8'h00);
        chk("R1 oe", {7'd0, bus_oe}, 8'h00);
        chk("R1 bus byte", bus_data_out, 8'h00);
        chk_regs("R1 regs");

        // R6 function write, R10 readback
        xfer(MY_ADDR, 1'b0, 3'd0, 8'hA5, 1'b0);
        xfer(MY_ADDR, 1'b1, 3'd3, 8'h00, 1'b1);
        // R7 data write, R8 status shows pending, ack clears
        xfer(MY_ADDR, 1'b0, 3'd1, 8'h3C, 1'b0);
        set_flags(6'h2B);
        xfer(MY_ADDR, 1'b1, 3'd0, 8'h00, 1'b1);
        ack_out();
        xfer(MY_ADDR, 1'b1, 3'd2, 8'h00, 1'b1);
        // R9 fill, second offer refused while full, read empties
        push_in(8'h77);
        push_in(8'h11);
        xfer(MY_ADDR, 1'b1, 3'd0, 8'h00, 1'b1);
        xfer(MY_ADDR, 1'b1, 3'd1, 8'h00, 1'b1);
        xfer(MY_ADDR, 1'b1, 3'd0, 8'h00, 1'b1);
        // R11 undefined orders both directions
        xfer(MY_ADDR, 1'b1, 3'd6, 8'h00, 1'b1);
        xfer(MY_ADDR, 1'b0, 3'd5, 8'hEE, 1'b0);
        xfer(MY_ADDR, 1'b1, 3'd3, 8'h00, 1'b1);
        // R12 data-phase direction ignored: output order with bus_dir high in data phase
        xfer(MY_ADDR, 1'b0, 3'd1, 8'h5A, 1'b1);
        xfer(MY_ADDR, 1'b1, 3'd2, 8'h00, 1'b0);
        // R2 foreign address, R5 stray strobes
        xfer(5'h0B, 1'b0, 3'd0, 8'hFF, 1'b0);
        stray(8'h99, 1'b0);
        stray(8'h42, 1'b1);
        // R2 deselect by a later foreign control byte
        @(negedge clk);
        bus_data_in = {MY_ADDR, 3'd0}; control_strobe = 1'b1; bus_dir = 1'b0;
        @(negedge clk);
        bus_data_in = {5'h03, 3'd0};
        @(negedge clk);
        control_strobe = 1'b0;
        chk("R2 deselect", {7'd0, bus_attached}, 8'h00);
        stray(8'hC3, 1'b0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [4:0] a;
            op = $urandom_range(0, 9);
            a  = ($urandom_range(0, 1) == 0) ? MY_ADDR : 5'($urandom);
            case (op)
                0: push_in(8'($urandom));
                1: ack_out();
                2: set_flags(6'($urandom));
                3: stray(8'($urandom), 1'($urandom));
                default: xfer(a, 1'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule